// File: doc/BRIEF.md
# Deferred Line Read Engine

This block lets a local processor start one read of a data line on an external bus and fetch the result later, without stalling on the bus. Software sets the interrupt masks and then writes a 32-bit target address. That write launches a master request on the bus. If the bus is busy, the request waits until the bus is free. While the read is outstanding, a pending flag is raised. Every word beat the bus returns is stored in a small line buffer, up to a parameterised number of words (8 by default).

When the bus signals completion, a done flag is raised. When the bus signals an abort, an abort flag is raised instead. Either flag can drive an interrupt line, subject to its own mask bit. Software then reads the buffer window repeatedly. Each read returns the next stored word. After the last valid word has been read, the buffer becomes empty and the done flag clears by itself. While a read is outstanding, the engine shields its own state from software: it ignores every write to it and every read of the buffer window.

Top module: `posted_read_engine`

## Requirements
- R1: After reset, the address register (offset 0x28) reads 0x8CA60028. The status register (offset 0x2C) reads 0. The mask register (offset 0x24) reads 0. `irq` and `bus_req` are low.
- R2: A write to offset 0x28 while no read is outstanding latches the address and sets the pending flag. The pending flag is status bit 0 and is read-only. Pending stays set until the bus reports done or abort.
- R3: If `bus_busy` is low when the address is written, `bus_req` rises in the next cycle. If `bus_busy` is high, `bus_req` stays low until the cycle after `bus_busy` is seen low. In both cases, `bus_addr` carries the latched address while `bus_req` is high.
- R4: A `bus_done` pulse during the request sets the done flag (status bit 8). A `bus_abort` pulse sets the abort flag (status bit 9) and leaves the buffer empty. If both arrive in the same cycle, only abort is recorded. All status bits other than 9, 8 and 0 read as zero.
- R5: Writing to offset 0x2C clears done where write-data bit 8 is 1 and clears abort where bit 9 is 1. A 0 in either bit leaves that flag unchanged.
- R6: `irq` is high when done is set with mask bit 0 of offset 0x24 clear, or when abort is set with mask bit 1 clear. Mask bits 1:0 read back at offset 0x24.
- R7: While pending is set, writes to offsets 0x24, 0x28 and 0x2C have no effect. Reads of the buffer window return 0 and do not consume a word. The status register can still be read.
- R8: Data beats accepted during the request are stored in arrival order. Beats beyond LINE_WORDS are dropped. The number of valid words equals the number of beats stored.
- R9: After a successful read, each read of offset 0x40 returns the next stored word. The read that returns the last valid word clears done. After that, buffer reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Local register write strobe |
| reg_rd | input | 1 | Local register read strobe (consumes a buffer word at 0x40) |
| reg_addr | input | 8 | Local register byte offset |
| reg_wdata | input | 32 | Local write data |
| reg_rdata | output | 32 | Local read data, combinational from reg_addr |
| irq | output | 1 | Masked done/abort interrupt |
| bus_req | output | 1 | Master read request, held until done or abort |
| bus_addr | output | 32 | Target address of the read |
| bus_busy | input | 1 | External bus occupied; defers the request |
| bus_beat | input | 1 | A data word is valid on bus_rdata |
| bus_rdata | input | 32 | Returned data word |
| bus_done | input | 1 | Read finished successfully |
| bus_abort | input | 1 | Read aborted |

## Verification
The hardest situation to reach is software activity landing while a read is still outstanding. The bench has to write the masks, the address and the status clear bits, and read the buffer window, all in the window between launch and completion. It then has to show afterwards that none of those accesses took effect. The stimulus holds the bus busy for a random number of cycles and spaces the data beats out, which keeps the request open long enough to insert those accesses. It then reads back the masks, the address and the buffer once the read has finished. Directed cases add line overflow, a read that returns no words, and done arriving in the same cycle as abort.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam logic [7:0]  OFS_MASK   = 8'h24;
  localparam logic [7:0]  OFS_TARGET = 8'h28;
  localparam logic [7:0]  OFS_STAT   = 8'h2C;
  localparam logic [7:0]  OFS_WINDOW = 8'h40;
  localparam logic [31:0] TARGET_RST = 32'h8CA6_0028;
  localparam int BIT_ABORT = 9;
  localparam int BIT_DONE  = 8;
  localparam int BIT_PEND  = 0;

  typedef enum logic [1:0] {FS_IDLE, FS_WAIT, FS_REQ} fetch_state_t;

  // Status word: abort bit 9, done bit 8, pending bit 0, all else zero.
  function automatic logic [31:0] pack_status(logic ab, logic dn, logic pn);
    logic [31:0] w;
    w = '0;
    w[BIT_ABORT] = ab;
    w[BIT_DONE]  = dn;
    w[BIT_PEND]  = pn;
    return w;
  endfunction

  function automatic logic irq_of(logic dn, logic ab, logic dmask, logic amask);
    return (dn & ~dmask) | (ab & ~amask);
  endfunction
endpackage

// File: rtl/prd_fetch.sv
module prd_fetch import prd_pkg::*; #(
  parameter int LINE_WORDS = 8,
  localparam int IW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int CW = $clog2(LINE_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          bus_busy,
  input  logic          bus_beat,
  input  logic          bus_done,
  input  logic          bus_abort,
  output logic          bus_req,
  output logic          pending,
  output logic          beat_we,
  output logic [IW-1:0] beat_idx,
  output logic [CW-1:0] beat_total,
  output logic          fin_ok,
  output logic          fin_abort
);
  fetch_state_t state;
  logic [CW-1:0] cnt;

  assign bus_req    = (state == FS_REQ);
  assign pending    = (state != FS_IDLE);
  assign beat_we    = bus_req & bus_beat & (cnt < CW'(LINE_WORDS));
  assign beat_idx   = cnt[IW-1:0];
  assign beat_total = beat_we ? cnt + CW'(1) : cnt;
  assign fin_abort  = bus_req & bus_abort;
  assign fin_ok     = bus_req & bus_done & ~bus_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= FS_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        FS_IDLE: if (launch) begin
          cnt   <= '0;
          state <= bus_busy ? FS_WAIT : FS_REQ;
        end
        FS_WAIT: if (!bus_busy) state <= FS_REQ;
        FS_REQ: begin
          if (bus_done || bus_abort) state <= FS_IDLE;
          else if (beat_we)          cnt   <= cnt + CW'(1);
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  a_r3_req_after_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !$past(bus_busy));
  a_r2_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !fin_ok && !fin_abort) |=> pending);
  a_r8_beat_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LINE_WORDS));
endmodule

// File: rtl/prd_linebuf.sv
module prd_linebuf #(
  parameter int LINE_WORDS = 8,
  parameter int DW = 32,
  localparam int IW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int CW = $clog2(LINE_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          capture,
  input  logic [CW-1:0] cap_count,
  input  logic          kill,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          drain_last
);
  logic [DW-1:0] mem [LINE_WORDS];
  logic [CW-1:0] count;
  logic [IW-1:0] ptr;
  logic          has_data;

  assign has_data   = (count != '0);
  assign rdata      = has_data ? mem[ptr] : '0;
  assign drain_last = rd & has_data & (CW'(ptr) == count - CW'(1));

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ptr   <= '0;
    end else if (kill) begin
      count <= '0;
      ptr   <= '0;
    end else if (capture) begin
      count <= cap_count;
      ptr   <= '0;
    end else if (rd && has_data) begin
      if (drain_last) begin
        count <= '0;
        ptr   <= '0;
      end else begin
        ptr <= ptr + IW'(1);
      end
    end
  end

  a_r9_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    has_data |-> (CW'(ptr) < count));
  a_r4_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !has_data);
endmodule

// File: rtl/posted_read_engine.sv
module posted_read_engine import prd_pkg::*; #(
  parameter int LINE_WORDS = 8,
  localparam int IW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int CW = $clog2(LINE_WORDS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        bus_req,
  output logic [31:0] bus_addr,
  input  logic        bus_busy,
  input  logic        bus_beat,
  input  logic [31:0] bus_rdata,
  input  logic        bus_done,
  input  logic        bus_abort
);
  logic          pending, wr_ok, launch, win_rd, clr_done, clr_abort;
  logic          fin_ok, fin_abort, beat_we, drain_last;
  logic [IW-1:0] beat_idx;
  logic [CW-1:0] beat_total;
  logic [31:0]   win_data, target_q;
  logic          done_q, abort_q, dmask_q, amask_q;

  // Named events, shielded while a read is outstanding.
  assign wr_ok     = reg_wr & ~pending;
  assign launch    = wr_ok & (reg_addr == OFS_TARGET);
  assign win_rd    = reg_rd & ~pending & (reg_addr == OFS_WINDOW);
  assign clr_done  = wr_ok & (reg_addr == OFS_STAT) & reg_wdata[BIT_DONE];
  assign clr_abort = wr_ok & (reg_addr == OFS_STAT) & reg_wdata[BIT_ABORT];

  prd_fetch #(.LINE_WORDS(LINE_WORDS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .bus_busy(bus_busy),
    .bus_beat(bus_beat), .bus_done(bus_done), .bus_abort(bus_abort),
    .bus_req(bus_req), .pending(pending), .beat_we(beat_we),
    .beat_idx(beat_idx), .beat_total(beat_total),
    .fin_ok(fin_ok), .fin_abort(fin_abort));

  prd_linebuf #(.LINE_WORDS(LINE_WORDS), .DW(32)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(beat_we), .widx(beat_idx),
    .wdata(bus_rdata), .capture(fin_ok), .cap_count(beat_total),
    .kill(fin_abort), .rd(win_rd), .rdata(win_data),
    .drain_last(drain_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q <= TARGET_RST;
      dmask_q  <= 1'b0;
      amask_q  <= 1'b0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      if (launch) target_q <= reg_wdata;
      if (wr_ok && reg_addr == OFS_MASK) begin
        dmask_q <= reg_wdata[0];
        amask_q <= reg_wdata[1];
      end
      if (fin_ok)                       done_q <= 1'b1;
      else if (clr_done || drain_last)  done_q <= 1'b0;
      if (fin_abort)                    abort_q <= 1'b1;
      else if (clr_abort)               abort_q <= 1'b0;
    end
  end

  assign bus_addr = target_q;
  assign irq      = irq_of(done_q, abort_q, dmask_q, amask_q);

  always_comb begin
    case (reg_addr)
      OFS_MASK:   reg_rdata = {30'b0, amask_q, dmask_q};
      OFS_TARGET: reg_rdata = target_q;
      OFS_STAT:   reg_rdata = pack_status(abort_q, done_q, pending);
      OFS_WINDOW: reg_rdata = pending ? 32'b0 : win_data;
      default:    reg_rdata = 32'b0;
    endcase
  end

  a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ok |=> (done_q && !pending));
  a_r4_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fin_abort |=> (abort_q && !pending));
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done && !drain_last) |=> done_q);
  a_r7_shielded: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !fin_ok && !fin_abort) |=> ($stable(target_q) && $stable({dmask_q, amask_q})));
  a_r9_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    drain_last |=> !done_q);
  a_r3_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> pending);
endmodule

// File: tb/sim_posted_read_engine.sv
module sim_posted_read_engine;
  localparam int CLK_NS = 10;
  localparam int LW = 8;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, bus_addr, bus_rdata = 0;
  logic        irq, bus_req, bus_busy = 0, bus_beat = 0, bus_done = 0, bus_abort = 0;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] m_target = 32'h8CA6_0028;
  logic        m_dm = 0, m_am = 0, m_done = 0, m_abort = 0;
  logic [31:0] m_mem [LW];
  int          m_cnt = 0, m_ptr = 0;

  posted_read_engine #(.LINE_WORDS(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .bus_req(bus_req), .bus_addr(bus_addr), .bus_busy(bus_busy),
    .bus_beat(bus_beat), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .bus_abort(bus_abort));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] f_status(logic pn);
    return (32'(m_abort) << 9) | (32'(m_done) << 8) | 32'(pn);
  endfunction
  function automatic logic f_irq();
    return (m_done && !m_dm) || (m_abort && !m_am);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  // mode 0 done, 1 abort, 2 both together
  task automatic run_read(int busy_cyc, int beats, int mode, bit poke);
    logic [31:0] a, d;
    a = $urandom;
    bus_busy = (busy_cyc > 0);
    wr(8'h28, a);
    m_target = a;
    rd(8'h2C, d); chk("R2 pending set", d, f_status(1));
    for (int i = 0; i < busy_cyc; i++) begin
      chk("R3 held while busy", 32'(bus_req), 0);
      @(negedge clk);
    end
    bus_busy = 0;
    if (busy_cyc > 0) @(negedge clk);
    chk("R3 request raised", 32'(bus_req), 1);
    chk("R3 bus address", bus_addr, a);
    if (poke) begin
      wr(8'h24, {30'b0, ~m_am, ~m_dm});
      wr(8'h28, ~a);
      wr(8'h2C, 32'h300);
      rd(8'h40, d); chk("R7 window blocked", d, 0);
      rd(8'h2C, d); chk("R7 status readable", d, f_status(1));
    end
    for (int i = 0; i < beats; i++) begin
      bus_beat = 1; bus_rdata = $urandom;
      if (i < LW) m_mem[i] = bus_rdata;
      @(negedge clk);
      if ($urandom_range(0, 2) == 0) begin bus_beat = 0; @(negedge clk); end
    end
    bus_beat = 0;
    chk("R2 pending until finish", 32'(bus_req), 1);
    bus_done = (mode != 1); bus_abort = (mode != 0);
    @(negedge clk);
    bus_done = 0; bus_abort = 0;
    if (mode == 0) begin
      m_done = 1; m_cnt = (beats > LW) ? LW : beats; m_ptr = 0;
    end else begin
      m_abort = 1; m_cnt = 0;
    end
    chk("R3 request dropped", 32'(bus_req), 0);
    rd(8'h2C, d); chk("R4 status after finish", d, f_status(0));
    chk("R6 irq", 32'(irq), 32'(f_irq()));
    if (poke) begin
      rd(8'h28, d); chk("R7 address unchanged", d, m_target);
      rd(8'h24, d); chk("R7 masks unchanged", d, {30'b0, m_am, m_dm});
    end
  endtask

  task automatic drain();
    logic [31:0] d;
    while (m_cnt > 0) begin
      rd(8'h40, d); chk("R9 window word", d, m_mem[m_ptr]);
      m_ptr++;
      if (m_ptr == m_cnt) begin m_cnt = 0; m_done = 0; end
    end
    rd(8'h40, d); chk("R9 empty window", d, 0);
    rd(8'h2C, d); chk("R9 done cleared", d, f_status(0));
  endtask

  task automatic set_masks(logic dm, logic am);
    logic [31:0] d;
    wr(8'h24, {30'b0, am, dm});
    m_dm = dm; m_am = am;
    rd(8'h24, d); chk("R6 mask readback", d, {30'b0, am, dm});
    chk("R6 irq after mask", 32'(irq), 32'(f_irq()));
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h28, d); chk("R1 address reset", d, 32'h8CA6_0028);
    rd(8'h2C, d); chk("R1 status reset", d, 0);
    rd(8'h24, d); chk("R1 mask reset", d, 0);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 bus_req reset", 32'(bus_req), 0);
    // R8/R9 directed short line
    run_read(0, 3, 0, 0);
    drain();
    // R8 overflow beyond line, with busy bus
    run_read(4, 11, 0, 0);
    chk("R8 overflow capped", 32'(m_cnt), LW);
    drain();
    // R4/R7 abort with accesses while pending
    run_read(2, 5, 1, 1);
    rd(8'h40, d); chk("R4 abort leaves buffer empty", d, 0);
    // R5 write zero keeps, write one clears
    wr(8'h2C, 32'h0);
    rd(8'h2C, d); chk("R5 zero write keeps", d, f_status(0));
    wr(8'h2C, 32'h200); m_abort = 0;
    rd(8'h2C, d); chk("R5 abort cleared", d, f_status(0));
    // R4 done and abort together
    run_read(0, 2, 2, 0);
    chk("R4 abort wins", 32'(m_done), 0);
    wr(8'h2C, 32'h300); m_abort = 0; m_done = 0;
    // zero-beat completion, then done cleared by write
    run_read(1, 0, 0, 1);
    rd(8'h40, d); chk("R8 empty line", d, 0);
    wr(8'h2C, 32'h100); m_done = 0;
    rd(8'h2C, d); chk("R5 done cleared", d, f_status(0));
    // random mix
    for (int it = 0; it < 40; it++) begin
      set_masks($urandom_range(0, 1), $urandom_range(0, 1));
      run_read($urandom_range(0, 3), $urandom_range(0, 10),
               ($urandom_range(0, 3) == 0) ? 1 : 0, $urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) drain();
      else begin
        d = {22'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'b0};
        wr(8'h2C, d);
        if (d[9]) m_abort = 0;
        if (d[8]) m_done = 0;
        rd(8'h2C, d); chk("R5 random clear", d, f_status(0));
        chk("R6 irq after clear", 32'(irq), 32'(f_irq()));
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule